// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio using the pulse-swallow method. It keeps the high-rate part of the division inside a small dual-modulus stage. That stage divides by 64 or by 65 and is modelled here as a digital counter. Behind it sit a 6-bit swallow counter and a 12-bit main counter. While swallow counts remain, the stage divides by 65. Once they run out, it divides by 64. When the main counter runs out, the division period ends, and the total ratio is 64·N + A input cycles.

The swallow value A and the main value N come from registers elsewhere, which hold them steady. The block reads them only when a new division period starts, so changing them never cuts a period short. A synchronous restart strobe reloads every counter at once, which lets the phase of the output pulse be aligned to an outside event. A pair that is not allowed is flagged on an error output and replaced by a safe ratio. A pair is not allowed when N is below 5 or N is not greater than A.

Top module: `pulse_swallow_divider`

## Requirements
- R1: For a legal pair (5 ≤ N ≤ 4095, 0 ≤ A ≤ 63, N > A), rising fp pulses are exactly 64·N + A input clock cycles apart.
- R2: fp is high for exactly one clock cycle per division period.
- R3: With A = 0 the period is exactly 64·N, so no 65-cycle prescaler period is inserted.
- R4: The boundary pairs give the formula values: A = 63 with N = 64 gives 4159, and A = 4 with N = 5 gives 324.
- R5: A change of A or N during a period leaves that period's length unchanged. The new ratio applies from the next period.
- R6: A clock edge with restart high reloads all counters from the current A and N and produces no fp pulse. The next fp appears in the cycle after the (64·N + A)-th following edge.
- R7: When N < 5 or N ≤ A, cfg_err is high in the cycle after the edge that sampled the pair. The period becomes 320 + A when A < 5 and 320 otherwise. With a legal pair, cfg_err is low.
- R8: While rst is high, fp and cfg_err are low. After rst falls, the first fp appears in the cycle after the (64·N + A)-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous strobe that reloads all counters |
| swallow_a | input | 6 | Swallow value A (0 to 63) |
| main_n | input | 12 | Main counter value N (5 to 4095) |
| fp | output | 1 | One-cycle pulse at the end of each division period (registered) |
| cfg_err | output | 1 | High when the sampled A/N pair is illegal (registered) |

## Verification
The main function is tried with several pairs: a mid-range pair with nonzero A, A = 0, the largest swallow value with a large N, and the smallest legal N with the largest A it allows. Together these separate a correct modulus switch from one that never swallows, one that always swallows, and one that is off by one prescaler cycle. Pairs are changed in mid-period, right at a boundary and through a restart. This tells apart a design that samples A and N only at reload from one that follows them live. Illegal pairs with small and large A check that the clamp and the flag act together.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int PSD_A_W    = 6;
  localparam int PSD_N_W    = 12;
  localparam int PSD_LOG2M  = 6;
  localparam int PSD_N_MIN  = 5;

  typedef enum logic {
    MOD_NARROW = 1'b0,
    MOD_WIDE   = 1'b1
  } psd_mod_e;
endpackage

// File: rtl/psd_cfg_guard.sv
module psd_cfg_guard #(
  parameter int AW   = psd_pkg::PSD_A_W,
  parameter int NW   = psd_pkg::PSD_N_W,
  parameter int NMIN = psd_pkg::PSD_N_MIN
) (
  input  logic [AW-1:0] a_raw,
  input  logic [NW-1:0] n_raw,
  output logic [AW-1:0] a_eff,
  output logic [NW-1:0] n_eff,
  output logic          bad
);
  localparam int PADW = NW - AW;

  logic [NW-1:0] a_wide;
  logic          n_small;
  logic          n_not_above_a;

  assign a_wide        = {{PADW{1'b0}}, a_raw};
  assign n_small       = (n_raw < NW'(NMIN));
  assign n_not_above_a = (n_raw <= a_wide);

  always_comb begin
    bad   = n_small | n_not_above_a;
    n_eff = n_raw;
    a_eff = a_raw;
    if (bad) begin
      n_eff = NW'(NMIN);
      if (a_raw >= AW'(NMIN)) a_eff = '0;
    end
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int LOG2M = psd_pkg::PSD_LOG2M
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  psd_pkg::psd_mod_e mode,
  output logic              tick
);
  import psd_pkg::*;
  localparam int CW = LOG2M + 1;
  localparam logic [CW-1:0] LOAD_NARROW = CW'((1 << LOG2M) - 1);
  localparam logic [CW-1:0] LOAD_WIDE   = CW'(1 << LOG2M);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) cnt_q <= (mode == MOD_WIDE) ? LOAD_WIDE : LOAD_NARROW;
    else      cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_WIDE); // R1
  AST_PRESC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    tick |-> load); // R1
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int AW = psd_pkg::PSD_A_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic          wide_next
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)                      cnt_q <= load_val;
    else if (step && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign wide_next = step ? (cnt_q > AW'(1)) : (cnt_q != '0);

  AST_SWALLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R3
  AST_SWALLOW_MONO: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
  parameter int NW = psd_pkg::PSD_N_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] load_val,
  input  logic          step,
  output logic          last
);
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)      cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == NW'(1));

  AST_MAIN_ALIVE: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0); // R1
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int AW    = psd_pkg::PSD_A_W,
  parameter int NW    = psd_pkg::PSD_N_W,
  parameter int LOG2M = psd_pkg::PSD_LOG2M,
  parameter int NMIN  = psd_pkg::PSD_N_MIN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [AW-1:0] swallow_a,
  input  logic [NW-1:0] main_n,
  output logic          fp,
  output logic          cfg_err
);
  import psd_pkg::*;

  logic [AW-1:0] a_eff;
  logic [NW-1:0] n_eff;
  logic          bad;
  logic          tick;
  logic          last;
  logic          wide_next;
  logic          period_end;
  logic          reload_all;
  logic          presc_load;
  psd_mod_e      mode;
  logic          fp_q;
  logic          err_q;

  psd_cfg_guard #(.AW(AW), .NW(NW), .NMIN(NMIN)) u_guard (
    .a_raw(swallow_a), .n_raw(main_n),
    .a_eff(a_eff), .n_eff(n_eff), .bad(bad)
  );

  assign period_end = tick & last;
  assign reload_all = rst | restart | period_end;
  assign presc_load = reload_all | tick;

  always_comb begin
    if (reload_all) mode = (a_eff != '0) ? MOD_WIDE : MOD_NARROW;
    else            mode = wide_next ? MOD_WIDE : MOD_NARROW;
  end

  psd_prescaler #(.LOG2M(LOG2M)) u_presc (
    .clk(clk), .rst(rst), .load(presc_load), .mode(mode), .tick(tick)
  );

  psd_swallow_ctr #(.AW(AW)) u_swallow (
    .clk(clk), .rst(rst), .load(reload_all), .load_val(a_eff),
    .step(tick), .wide_next(wide_next)
  );

  psd_main_ctr #(.NW(NW)) u_main (
    .clk(clk), .rst(rst), .load(reload_all), .load_val(n_eff),
    .step(tick), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      fp_q  <= period_end & ~restart;
      err_q <= bad;
    end
  end

  assign fp      = fp_q;
  assign cfg_err = err_q;

  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp); // R2
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    restart |=> !fp); // R6
  AST_CLAMP_APPLIED: assert property (@(posedge clk) disable iff (rst)
    bad |-> (n_eff == NW'(NMIN))); // R7
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cfg_err == $past(bad))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!fp && !cfg_err)); // R8
endmodule

// File: tb/tb_pulse_swallow_divider.sv
module tb_pulse_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [5:0]  swallow_a = 6'd3;
  logic [11:0] main_n = 12'd7;
  logic        fp;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int m_cnt = 0;
  int m_per = 0;
  bit m_fp  = 0;
  bit m_err = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_divider dut (
    .clk(clk), .rst(rst), .restart(restart),
    .swallow_a(swallow_a), .main_n(main_n),
    .fp(fp), .cfg_err(cfg_err)
  );

  function automatic bit illegal(int a, int n);
    return (n < 5) || (n <= a);
  endfunction

  function automatic int period_of(int a, int n);
    if (illegal(a, n)) begin
      n = 5;
      if (a >= 5) a = 0;
    end
    return 64 * n + a;
  endfunction

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = period_of(swallow_a, main_n); m_fp = 0; m_err = 0;
    end else begin
      m_err = illegal(swallow_a, main_n);
      if (restart) begin
        m_cnt = 0; m_per = period_of(swallow_a, main_n); m_fp = 0;
      end else begin
        m_cnt++;
        if (m_cnt == m_per) begin
          m_fp = 1; m_cnt = 0; m_per = period_of(swallow_a, main_n);
        end else m_fp = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      checks++;
      if (fp !== m_fp) begin
        fails++;
        $display("FAIL R1 fp per-cycle: actual %0b expected %0b at cycle %0d", fp, m_fp, cyc);
      end
      checks++;
      if (cfg_err !== m_err) begin
        fails++;
        $display("FAIL R7 cfg_err per-cycle: actual %0b expected %0b at cycle %0d", cfg_err, m_err, cyc);
      end
      if (cyc > 180000) begin
        done = 1;
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (fp !== 1'b1 && n < 20000);
  endtask

  task automatic wait_pulse();
    int n;
    gap(n);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    check_int("R8 fp low in reset", int'(fp), 0);
    check_int("R8 cfg_err low in reset", int'(cfg_err), 0);
    rst = 1'b0;
    gap(g); check_int("R8 first period after reset", g, 451);
    gap(g); check_int("R1 period A=3 N=7", g, 451);
    gap(g); check_int("R2 next period A=3 N=7", g, 451);

    // change right after a boundary: current period keeps old length
    swallow_a = 6'd0; main_n = 12'd5;
    gap(g); check_int("R5 running period unchanged", g, 451);
    gap(g); check_int("R3 A=0 N=5", g, 320);

    // change mid-period
    repeat (50) @(negedge clk);
    swallow_a = 6'd9; main_n = 12'd10;
    gap(g); check_int("R5 mid-period change ignored", g, 320 - 50);
    gap(g); check_int("R1 period A=9 N=10", g, 649);

    swallow_a = 6'd63; main_n = 12'd64;
    wait_pulse();
    gap(g); check_int("R4 A=63 N=64", g, 4159);
    swallow_a = 6'd4; main_n = 12'd5;
    wait_pulse();
    gap(g); check_int("R4 A=4 N=5", g, 324);

    // restart in mid-period
    repeat (100) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_int("R6 no pulse on restart edge", int'(fp), 0);
    gap(g); check_int("R6 period after restart", g, 324);
    restart = 1'b1; swallow_a = 6'd2; main_n = 12'd6;
    @(negedge clk);
    restart = 1'b0;
    gap(g); check_int("R6 restart picks new pair", g, 386);

    // illegal pairs
    swallow_a = 6'd1; main_n = 12'd3;
    @(negedge clk);
    check_int("R7 flag N<5", int'(cfg_err), 1);
    wait_pulse();
    gap(g); check_int("R7 clamp N<5 keeps A", g, 321);
    swallow_a = 6'd6; main_n = 12'd6;
    @(negedge clk);
    check_int("R7 flag N<=A", int'(cfg_err), 1);
    wait_pulse();
    gap(g); check_int("R7 clamp N<=A drops A", g, 320);
    swallow_a = 6'd1; main_n = 12'd8;
    @(negedge clk);
    check_int("R7 flag clears on legal pair", int'(cfg_err), 0);
    wait_pulse();
    gap(g); check_int("R1 period A=1 N=8", g, 513);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_int("R8 fp low after reset", int'(fp), 0);
    rst = 1'b0;
    gap(g); check_int("R8 first period after second reset", g, 513);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule